// File: doc/BRIEF.md
# Clock Generator Configuration Register Bank

This block is the control plane of a multi-output clock generator. It keeps seven byte-wide configuration registers that a host reaches over a two-wire serial slave port (start/stop framing, 8-bit bytes, 9th-clock acknowledge). Its outputs drive the synthesizer and the output buffers: the effective 4-bit frequency code, the spread-spectrum controls, a global high-impedance control, the selection of the shared 24/48 MHz output, and one enable line per clock output. The frequency synthesis itself is not part of this block.

While the power-up reset is held low, four frequency-strap pins are captured into the registers. Their inverted values read back at scattered bit positions. A mode bit decides whether the frequency code comes from those straps or from a software code whose four bits sit in non-adjacent positions of register 0. Reserved bits, the strap bits and the identification register are read-only. Every change of the effective frequency code raises a one-cycle change pulse, so the synthesizer can start a smooth retune.

A host write is: start, device address with R/W=0, two bytes that are acknowledged and discarded, and then data bytes that fill registers 0, 1, 2 and so on until stop. A host read is: start, device address with R/W=1, and then bytes from register 0 upward for as long as the host acknowledges.

Top module: `clkgen_ctrl_regs`

## Requirements
- R1: While rst_n is low, all registers take their power-up values. Register 0 becomes 0x00. Every enable bit and every reserved bit becomes 1. Register 3 bit 7 becomes 1. The strap read-back bits load from strap_fs. The registers never reload at any other time.
- R2: The slave answers only the 7-bit address 0x69 (address byte 0xD2 for a write, 0xD3 for a read) by pulling SDA low on the 9th clock. Any other address gets no acknowledge and changes no register.
- R3: In a write, the two bytes that follow the address are acknowledged and discarded. Each later data byte is acknowledged and goes to register 0, then register 1, and so on in order.
- R4: In a read, the bytes come out MSB first, starting at register 0 and stepping one register per byte. They continue while the host acknowledges, and a host NACK ends the transfer. SDA is driven or released only while SCL is low.
- R5: freq_code equals strap_fs (as captured at reset) when register 0 bit 3 is 0. When that bit is 1, freq_code is {reg0[2], reg0[6], reg0[5], reg0[4]}. Code 0000 means 66.8/100.2/33.4 MHz and code 1111 means 166/166/33.3 MHz (CPU/SDRAM/PCI).
- R6: spread_en = reg0[1]. spread_down = spread_en & ~reg1[5]. spread_wide (±0.75 % rather than ±0.5 % centre spread) = spread_en & reg1[5] & reg0[7]. The down-spread setting overrides reg0[7].
- R7: outputs_hiz follows register 0 bit 0.
- R8: The straps read back inverted: strap bit 2 at reg1[7], bit 0 at reg3[6], bit 1 at reg4[3] and bit 3 at reg4[1]. Writes to these four bits have no effect.
- R9: Reserved bits (reg1 bits 6, 4, 0; reg2 bit 7; reg3 bits 3, 2) always read 1 and ignore writes.
- R10: Register 6 always reads 0x59 and ignores writes. An index past register 6 reads 0xFF, and a write to such an index is dropped.
- R11: The enables map as follows. cpu_en[2:0] = reg1[3:1]. pci_en[6:0] = reg2[6:0]. usb48_en = reg3[5]. fixed_mux_en = reg3[4]. ref_en[1:0] = reg3[1:0]. sdram_en[13:0] = {reg4[7:4], reg4[2], reg4[0], reg5[7:0]}.
- R12: fixed_24m_sel follows reg3[7]. A value of 1 selects 24 MHz and 0 selects 48 MHz.
- R13: freq_chg is high for exactly one cycle in the cycle in which freq_code takes a new value. It stays low when a write leaves the code unchanged and just after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| strap_fs | input | 4 | Frequency strap pins, captured during reset |
| scl_i | input | 1 | Serial clock line, already synchronised |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| freq_code | output | 4 | Effective frequency code |
| freq_chg | output | 1 | One-cycle pulse on a new frequency code |
| spread_en | output | 1 | Spread spectrum on |
| spread_down | output | 1 | 0 to 0.5 % down spread chosen |
| spread_wide | output | 1 | ±0.75 % centre spread chosen |
| outputs_hiz | output | 1 | All clock outputs to high impedance |
| fixed_24m_sel | output | 1 | Shared fixed output at 24 MHz (1) or 48 MHz (0) |
| cpu_en | output | 3 | Host clock enables |
| pci_en | output | 7 | PCI clock enables |
| sdram_en | output | 14 | Memory clock enables |
| ref_en | output | 2 | Reference clock enables |
| usb48_en | output | 1 | 48 MHz output enable |
| fixed_mux_en | output | 1 | Shared 24/48 MHz output enable |

## Verification
On every cycle, the assertions check four things: the read-only parts of the register image (the identification byte, the reserved ones and the captured strap bits) stay fixed; the slave moves SDA only while SCL is low or at a start/stop; a register write always coincides with an acknowledge; and the down-spread and wide-spread controls are never both on while the change pulse never lasts two cycles. Only the bench's transactions can show the address decoding, the order in which data bytes land and read back, the discarding of the command and count bytes, the enable mapping, the choice between strap and software code, and that a rewrite of an unchanged code produces no pulse. The bench covers two different strap patterns across two power-up resets.

// File: rtl/cgr_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, register indices and the serial slave state type.
// Assumes a fixed seven-register image; the masks below define which bits
// software may change.
package cgr_pkg;

    localparam int          NUM_REGS = 7;
    localparam int          IDX_W    = $clog2(NUM_REGS) + 1;
    localparam logic [7:0]  ID_VALUE = 8'h59;

    localparam int REG_MODE = 0;   // code source, software code, spread, hiz
    localparam int REG_HOST = 1;   // host enables, spread type, strap bit
    localparam int REG_PCI  = 2;   // PCI enables
    localparam int REG_FIX  = 3;   // fixed outputs, 24/48 select, strap bit
    localparam int REG_MEMH = 4;   // upper memory enables, two strap bits
    localparam int REG_MEML = 5;   // lower memory enables
    localparam int REG_ID   = 6;   // identification, read-only

    typedef logic [7:0] byte_t;

    typedef enum logic [2:0] {
        TW_IDLE, TW_ADDR, TW_CMD, TW_CNT, TW_WDAT, TW_RDAT
    } tw_state_e;

    // Bits that a host write may change in register i.
    function automatic byte_t wr_mask(input int i);
        case (i)
            REG_MODE: return 8'hFF;
            REG_HOST: return 8'h2E;
            REG_PCI:  return 8'h7F;
            REG_FIX:  return 8'hB3;
            REG_MEMH: return 8'hF5;
            REG_MEML: return 8'hFF;
            default:  return 8'h00;
        endcase
    endfunction

    // Power-up content of register i, straps captured inverted.
    function automatic byte_t power_up_image(input int i, input logic [3:0] s);
        case (i)
            REG_MODE: return 8'h00;
            REG_HOST: return {~s[2], 7'h7F};
            REG_PCI:  return 8'hFF;
            REG_FIX:  return {1'b1, ~s[0], 6'h3F};
            REG_MEMH: return {4'hF, ~s[1], 1'b1, ~s[3], 1'b1};
            REG_MEML: return 8'hFF;
            REG_ID:   return ID_VALUE;
            default:  return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/cgr_twi_slave.sv
`timescale 1ns/1ps
// Module: two-wire serial slave. Detects start/stop and SCL edges on
// oversampled lines, acknowledges its address, discards the two bytes after a
// write address, then issues one write strobe per data byte with an
// auto-incrementing index. Reads stream bytes from index 0 upward.
// Assumes scl_i/sda_i are already synchronous to clk and SCL phases span
// several clk cycles.
module cgr_twi_slave
    import cgr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         IW       = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic [IW-1:0] rd_idx,
    input  logic [7:0]    rd_data
);

    logic          scl_s, scl_d, sda_s, sda_d;
    logic          start_det, stop_det, scl_rise, scl_fall;
    tw_state_e     st;
    logic [3:0]    bit_cnt;
    logic [7:0]    shreg;
    logic          rw;
    logic [IW-1:0] idx;
    logic [2:0]    bsel;

    function automatic logic [IW-1:0] sat_inc(input logic [IW-1:0] v);
        return (v == '1) ? v : v + IW'(1);
    endfunction

    // Line sampling: one stage of history for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_s <= 1'b1; scl_d <= 1'b1; sda_s <= 1'b1; sda_d <= 1'b1;
        end else begin
            scl_s <= scl_i; scl_d <= scl_s; sda_s <= sda_i; sda_d <= sda_s;
        end
    end

    // Bus events derived from the sampled lines.
    always_comb begin
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        bsel      = 3'(4'd7 - bit_cnt);
    end

    // Protocol engine: shifts on SCL rise, drives SDA on SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= TW_IDLE; bit_cnt <= '0; shreg <= '0; rw <= 1'b0;
            idx <= '0; sda_oe <= 1'b0; wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                st <= TW_ADDR; bit_cnt <= '0; idx <= '0; sda_oe <= 1'b0;
            end else if (stop_det) begin
                st <= TW_IDLE; sda_oe <= 1'b0;
            end else if (scl_rise) begin
                case (st)
                    TW_ADDR, TW_CMD, TW_CNT, TW_WDAT: begin
                        if (bit_cnt < 4'd8) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (bit_cnt == 4'd8) begin
                            bit_cnt <= 4'd9;
                        end
                    end
                    TW_RDAT: begin
                        if (bit_cnt == 4'd8) begin
                            if (sda_s) st <= TW_IDLE;
                            else       bit_cnt <= 4'd9;
                        end else if (bit_cnt < 4'd8) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (st)
                    TW_ADDR, TW_CMD, TW_CNT, TW_WDAT: begin
                        if (bit_cnt == 4'd8) begin
                            if (st == TW_ADDR && shreg[7:1] != DEV_ADDR) begin
                                st <= TW_IDLE;
                            end else begin
                                sda_oe <= 1'b1;
                                if (st == TW_ADDR) rw <= shreg[0];
                                if (st == TW_WDAT) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= idx;
                                    wr_data <= shreg;
                                    idx     <= sat_inc(idx);
                                end
                            end
                        end else if (bit_cnt == 4'd9) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            case (st)
                                TW_ADDR: begin
                                    if (rw) begin
                                        st     <= TW_RDAT;
                                        sda_oe <= ~rd_data[7];
                                    end else begin
                                        st <= TW_CMD;
                                    end
                                end
                                TW_CMD:  st <= TW_CNT;
                                TW_CNT:  st <= TW_WDAT;
                                default: ;
                            endcase
                        end
                    end
                    TW_RDAT: begin
                        if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
                            sda_oe <= ~rd_data[bsel];
                        end else if (bit_cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            idx    <= sat_inc(idx);
                        end else if (bit_cnt == 4'd9) begin
                            bit_cnt <= '0;
                            sda_oe  <= ~rd_data[7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_idx = idx;

    // SDA may only move while SCL is low, or at a start/stop.
    assert_sda_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> ($past(!scl_s) || $past(start_det) || $past(stop_det)));

    // An idle slave never holds the data line.
    assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TW_IDLE) |-> !sda_oe);

    // Every register write coincides with an acknowledge being driven.
    assert_write_acked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe);

endmodule

// File: rtl/cgr_regbank.sv
`timescale 1ns/1ps
// Module: seven-byte register image. Each register applies its own write
// mask, so read-only strap, reserved and identification bits keep their
// power-up content. Straps are captured while reset is held.
// Assumes strap_i is stable during reset.
module cgr_regbank
    import cgr_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    strap_i,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output byte_t         regs_o [NUM_REGS]
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam byte_t WM = wr_mask(g);
        byte_t q;
        // Register g: power-up load, masked update on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= power_up_image(g, strap_i);
            else if (wr_en && wr_idx == IW'(g))
                q <= (q & ~WM) | (wr_data & WM);
        end
        assign regs_o[g] = q;
    end

    // Read multiplexer; indices past the image read as all ones.
    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == IW'(i)) rd_data = regs_o[i];
    end

    assert_id_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        regs_o[REG_ID] == ID_VALUE);

    assert_strap_bits_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $stable({regs_o[REG_HOST][7], regs_o[REG_FIX][6], regs_o[REG_MEMH][3], regs_o[REG_MEMH][1]}));

    assert_reserved_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_o[REG_HOST] & 8'h51) == 8'h51) && regs_o[REG_PCI][7] &&
        ((regs_o[REG_FIX] & 8'h0C) == 8'h0C));

endmodule

// File: rtl/cgr_ctrl_map.sv
`timescale 1ns/1ps
// Module: decodes the register image into synthesizer and buffer controls,
// selects the frequency code source and flags every code change.
// Assumes the register image changes at most once every few cycles.
module cgr_ctrl_map
    import cgr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  strap_i,
    input  byte_t       regs_i [NUM_REGS],
    output logic [3:0]  freq_code,
    output logic        freq_chg,
    output logic        spread_en,
    output logic        spread_down,
    output logic        spread_wide,
    output logic        outputs_hiz,
    output logic        fixed_24m_sel,
    output logic [2:0]  cpu_en,
    output logic [6:0]  pci_en,
    output logic [13:0] sdram_en,
    output logic [1:0]  ref_en,
    output logic        usb48_en,
    output logic        fixed_mux_en
);

    byte_t      r_mode, r_host, r_pci, r_fix, r_memh, r_meml;
    logic [3:0] hw_code, sw_code, code_prev;
    logic       unused_bits;

    // Field extraction and code source selection.
    always_comb begin
        r_mode = regs_i[REG_MODE];
        r_host = regs_i[REG_HOST];
        r_pci  = regs_i[REG_PCI];
        r_fix  = regs_i[REG_FIX];
        r_memh = regs_i[REG_MEMH];
        r_meml = regs_i[REG_MEML];
        hw_code   = ~{r_memh[1], r_host[7], r_memh[3], r_fix[6]};
        sw_code   = {r_mode[2], r_mode[6:4]};
        freq_code = r_mode[3] ? sw_code : hw_code;
        freq_chg  = (freq_code != code_prev);
    end

    // Previous effective code, seeded from the straps at power-up.
    always_ff @(posedge clk) begin
        if (!rst_n) code_prev <= strap_i;
        else        code_prev <= freq_code;
    end

    // Spread, tristate and output enable decode.
    always_comb begin
        spread_en     = r_mode[1];
        spread_down   = r_mode[1] & ~r_host[5];
        spread_wide   = r_mode[1] & r_host[5] & r_mode[7];
        outputs_hiz   = r_mode[0];
        fixed_24m_sel = r_fix[7];
        cpu_en        = r_host[3:1];
        pci_en        = r_pci[6:0];
        usb48_en      = r_fix[5];
        fixed_mux_en  = r_fix[4];
        ref_en        = r_fix[1:0];
        sdram_en      = {r_memh[7:4], r_memh[2], r_memh[0], r_meml};
    end

    assign unused_bits = ^{r_host[6], r_host[4], r_host[0], r_pci[7], r_fix[3:2], regs_i[REG_ID]};

    assert_spread_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spread_down |-> (!spread_wide && spread_en));

    assert_chg_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        freq_chg |=> !freq_chg);

endmodule

// File: rtl/clkgen_ctrl_regs.sv
`timescale 1ns/1ps
// Module: top of the clock generator configuration block. Connects the
// serial slave, the register image and the control decode.
// Assumes one clock domain; the serial lines arrive pre-synchronised.
module clkgen_ctrl_regs #(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  strap_fs,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic [3:0]  freq_code,
    output logic        freq_chg,
    output logic        spread_en,
    output logic        spread_down,
    output logic        spread_wide,
    output logic        outputs_hiz,
    output logic        fixed_24m_sel,
    output logic [2:0]  cpu_en,
    output logic [6:0]  pci_en,
    output logic [13:0] sdram_en,
    output logic [1:0]  ref_en,
    output logic        usb48_en,
    output logic        fixed_mux_en
);
    import cgr_pkg::*;

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;
    byte_t            regs [NUM_REGS];

    cgr_twi_slave #(.DEV_ADDR(DEV_ADDR), .IW(IDX_W)) u_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    cgr_regbank #(.IW(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_fs),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(regs)
    );

    cgr_ctrl_map u_map (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_fs), .regs_i(regs),
        .freq_code(freq_code), .freq_chg(freq_chg),
        .spread_en(spread_en), .spread_down(spread_down), .spread_wide(spread_wide),
        .outputs_hiz(outputs_hiz), .fixed_24m_sel(fixed_24m_sel),
        .cpu_en(cpu_en), .pci_en(pci_en), .sdram_en(sdram_en), .ref_en(ref_en),
        .usb48_en(usb48_en), .fixed_mux_en(fixed_mux_en)
    );

endmodule

// File: tb/sim_clkgen_ctrl_regs.sv
`timescale 1ns/1ps
module sim_clkgen_ctrl_regs;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [3:0]  strap = 4'b0101;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        sda_oe, freq_chg, spread_en, spread_down, spread_wide;
    logic        outputs_hiz, fixed_24m_sel, usb48_en, fixed_mux_en;
    logic [3:0]  freq_code;
    logic [2:0]  cpu_en;
    logic [6:0]  pci_en;
    logic [13:0] sdram_en;
    logic [1:0]  ref_en;
    wire         sda_line = sda_m & ~sda_oe;

    clkgen_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .strap_fs(strap), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .freq_code(freq_code), .freq_chg(freq_chg),
        .spread_en(spread_en), .spread_down(spread_down), .spread_wide(spread_wide),
        .outputs_hiz(outputs_hiz), .fixed_24m_sel(fixed_24m_sel),
        .cpu_en(cpu_en), .pci_en(pci_en), .sdram_en(sdram_en), .ref_en(ref_en),
        .usb48_en(usb48_en), .fixed_mux_en(fixed_mux_en)
    );

    // Scoreboard
    typedef struct { string req; logic [31:0] val; } item_t;
    item_t       exp_q[$];
    logic [31:0] act_q[$];
    int n_vec = 0, n_bad = 0, chg_cnt = 0;
    bit done = 0;

    task automatic push_exp(input string req, input logic [31:0] e);
        exp_q.push_back('{req, e});
    endtask
    task automatic push_act(input logic [31:0] a);
        act_q.push_back(a);
    endtask

    always @(negedge clk) begin
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            item_t e;
            logic [31:0] a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_vec++;
            if (a !== e.val) begin
                n_bad++;
                $display("FAIL %s: actual %0h expected %0h", e.req, a, e.val);
            end
        end
    end

    always @(negedge clk) if (rst_n && freq_chg) chg_cnt++;

    // Reference model built from the requirements
    logic [7:0] shadow [7];

    function automatic logic [7:0] m_mask(input int i);
        case (i) 0: return 8'hFF; 1: return 8'h2E; 2: return 8'h7F; 3: return 8'hB3;
                 4: return 8'hF5; 5: return 8'hFF; default: return 8'h00; endcase
    endfunction
    function automatic logic [7:0] m_pu(input int i, input logic [3:0] s);
        case (i) 0: return 8'h00; 1: return {~s[2], 7'h7F}; 2: return 8'hFF;
                 3: return {1'b1, ~s[0], 6'h3F};
                 4: return {4'hF, ~s[1], 1'b1, ~s[3], 1'b1};
                 5: return 8'hFF; default: return 8'h59; endcase
    endfunction
    // Nominal CPU frequency in units of 0.1 MHz for the two table ends (R5).
    function automatic int m_cpu_tenths(input logic [3:0] c);
        return (c == 4'b1111) ? 1660 : (c == 4'b0000) ? 668 : 0;
    endfunction

    task automatic hold(); repeat (4) @(negedge clk); endtask

    task automatic power_up(input logic [3:0] s);
        @(negedge clk) rst_n = 1'b0; strap = s; scl_m = 1'b1; sda_m = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 7; i++) shadow[i] = m_pu(i, s);
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; hold(); sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
    endtask
    task automatic bus_stop();
        sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
    endtask
    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0; hold();
        end
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); ack = !sda_line; scl_m = 1'b0; hold();
    endtask
    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            hold(); scl_m = 1'b1; hold(); b[i] = sda_line; scl_m = 1'b0;
        end
        hold(); sda_m = mack ? 1'b0 : 1'b1; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0; hold();
        sda_m = 1'b1;
    endtask

    // Write transaction: address, two discarded bytes, then n data bytes (R2, R3)
    task automatic write_seq(input logic [6:0] addr, input int n,
                             input logic [7:0] d [7]);
        bit ack;
        bit hit = (addr == 7'h69);
        bus_start();
        send_byte({addr, 1'b0}, ack);
        push_exp("R2 address acknowledge", 32'(hit)); push_act(32'(ack));
        if (hit) begin
            send_byte(8'hC3, ack); push_exp("R3 command byte ack", 1); push_act(32'(ack));
            send_byte(8'h17, ack); push_exp("R3 count byte ack", 1);   push_act(32'(ack));
            for (int i = 0; i < n; i++) begin
                send_byte(d[i], ack);
                push_exp("R3 data byte ack", 1); push_act(32'(ack));
                if (i < 7) shadow[i] = (shadow[i] & ~m_mask(i)) | (d[i] & m_mask(i));
            end
        end
        bus_stop();
    endtask

    // Read transaction from register 0 upward (R4, R8, R9, R10)
    task automatic read_seq(input int n);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, ack);
        push_exp("R2 read address acknowledge", 1); push_act(32'(ack));
        for (int i = 0; i < n; i++) begin
            push_exp(i == 6 ? "R10 id read" : "R4 R8 R9 register read", 32'(shadow[i]));
            recv_byte(i != n - 1, b);
            push_act(32'(b));
        end
        bus_stop();
    endtask

    // Port checks against the model (R1, R5, R6, R7, R11, R12)
    task automatic check_ports();
        logic [7:0] r0 = shadow[0], r1 = shadow[1], r2 = shadow[2];
        logic [7:0] r3 = shadow[3], r4 = shadow[4], r5 = shadow[5];
        logic [3:0] code = r0[3] ? {r0[2], r0[6:4]} : strap;
        @(negedge clk);
        push_exp("R5 freq_code", 32'(code));               push_act(32'(freq_code));
        push_exp("R5 table end", 32'(m_cpu_tenths(code))); push_act(32'(m_cpu_tenths(freq_code)));
        push_exp("R6 spread_en", 32'(r0[1]));              push_act(32'(spread_en));
        push_exp("R6 spread_down", 32'(r0[1] & ~r1[5]));   push_act(32'(spread_down));
        push_exp("R6 spread_wide", 32'(r0[1] & r1[5] & r0[7])); push_act(32'(spread_wide));
        push_exp("R7 outputs_hiz", 32'(r0[0]));            push_act(32'(outputs_hiz));
        push_exp("R12 fixed_24m_sel", 32'(r3[7]));         push_act(32'(fixed_24m_sel));
        push_exp("R11 cpu_en", 32'(r1[3:1]));              push_act(32'(cpu_en));
        push_exp("R11 pci_en", 32'(r2[6:0]));              push_act(32'(pci_en));
        push_exp("R11 sdram_en", 32'({r4[7:4], r4[2], r4[0], r5})); push_act(32'(sdram_en));
        push_exp("R11 fixed enables", 32'({r3[5], r3[4], r3[1:0]}));
        push_act(32'({usb48_en, fixed_mux_en, ref_en}));
    endtask

    task automatic check_pulses(input string req, input int base, input int exp_n);
        repeat (4) @(negedge clk);
        push_exp(req, 32'(exp_n)); push_act(32'(chg_cnt - base));
    endtask

    initial begin
        logic [7:0] d [7];
        int base;
        // R1: power-up state with straps 0101
        power_up(4'b0101);
        check_ports();
        push_exp("R13 no pulse after reset", 0); push_act(32'(chg_cnt));
        read_seq(7);

        // R2: foreign address is not acknowledged and changes nothing
        d = '{8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        write_seq(7'h6A, 2, d);
        check_ports();
        read_seq(2);

        // R3, R5, R6, R8, R9, R10, R11, R12, R13: full write of all seven registers
        base = chg_cnt;
        d = '{8'h3A, 8'h00, 8'h55, 8'h00, 8'h00, 8'hA5, 8'h00};
        write_seq(7'h69, 7, d);
        check_pulses("R13 pulse on software code", base, 1);
        check_ports();
        read_seq(7);

        // R13: rewriting the same code gives no pulse
        base = chg_cnt;
        d[0] = 8'h3A;
        write_seq(7'h69, 1, d);
        check_pulses("R13 no pulse on same code", base, 0);

        // R6, R7: wide centre spread, tristate, back to strap code
        base = chg_cnt;
        d[0] = 8'h83; d[1] = 8'h20;
        write_seq(7'h69, 2, d);
        check_pulses("R13 pulse on return to straps", base, 1);
        check_ports();

        // R5: software code 1111, spread off
        base = chg_cnt;
        d[0] = 8'hFC;
        write_seq(7'h69, 1, d);
        check_pulses("R13 pulse on code 1111", base, 1);
        check_ports();

        // R4: short read ended by NACK after two bytes
        read_seq(2);

        // R1, R8: second power-up with straps 1010
        base = chg_cnt;
        power_up(4'b1010);
        check_pulses("R13 no pulse across reset", base, 0);
        check_ports();
        read_seq(7);

        wait (act_q.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule